// File: doc/BRIEF.md
# Windowed Remote Access Requester

This block is the local end of a two-endpoint link that carries traffic both ways. An initiator on a simple memory-mapped slave port issues reads and writes. If an address falls inside one of up to four programmable windows, the access is remapped into the remote address space and sent as a command packet on a byte-wide transmit stream. An access that hits no window never leaves the block.

Writes are posted: the initiator is released as soon as the command is queued in the transmit shifter. Reads keep the initiator stalled until the matching response packet arrives on the byte-wide receive stream. If no response arrives, a programmable timeout ends the read with an error.

Window and timeout settings are written through a small configuration port. A bit set in a window's mask marks an address bit that must equal the window's local base.

Top module: `win_link_req`

## Requirements
- R1: A window matches when its enable bit (config field 3, bit 0) is set and `((addr ^ local_base) & mask) == 0`. A disabled window never matches. After reset every window is disabled. Config address: bit 4 = 0 selects window `cfg_addr[3:2]` and field `cfg_addr[1:0]` (0 local base, 1 mask, 2 remote base, 3 enable). Config address 0x10 is the timeout limit.
- R2: The remote address placed in a packet is `addr - local_base + remote_base` of the matching window.
- R3: When several windows match, the lowest-numbered one is used.
- R4: An access that matches no window gets `bus_ready` with `bus_err`=1 and `bus_rdata`=0, and sends no byte.
- R5: A write that hits a window sends 9 bytes: 0x01, four address bytes most significant first, then four data bytes most significant first. `bus_ready` is returned one cycle after the request is seen, even if the transmit stream is stalled.
- R6: A read that hits a window sends 5 bytes: 0x02, then four address bytes most significant first. `bus_ready` stays low until the read ends.
- R7: A response is the byte 0x82 followed by four data bytes, most significant first. It ends a pending read with `bus_err`=0 and that data. While the receiver is waiting for a type byte, any other byte is ignored.
- R8: A response that arrives while no read is pending is discarded. It has no effect on later reads.
- R9: A read with no response is ended after the programmable limit (default 200 cycles) with `bus_err`=1 and `bus_rdata`=0xFFFFFFFF.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R11: After reset `bus_ready` and `tx_valid` are low.
- R12: A hit access that arrives while a packet is still queued for transmission is held not-ready until the transmitter is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | input | 1 | Access request, held until `bus_ready` is seen |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Local address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error flag, valid with `bus_ready` |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink accepts the byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |

## Verification
A corrupted window register or a wrong priority shows up in the first packet after the access: the address bytes differ, or an error completion appears one cycle after the request. A parser left out of its hunting state turns a stray response into stale read data on the very next read. A stuck wait state appears as a read that ends with the timeout error and all-ones data, only after the full limit has run. A shifter that loses its place shows as the wrong byte count or byte order in the packet it is sending.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int WORD_BY  = WORD_W / BYTE_W;

    localparam logic [BYTE_W-1:0] TYPE_WR  = 8'h01;
    localparam logic [BYTE_W-1:0] TYPE_RD  = 8'h02;
    localparam logic [BYTE_W-1:0] TYPE_RSP = 8'h82;

    localparam logic [1:0] FLD_LBASE = 2'd0;
    localparam logic [1:0] FLD_MASK  = 2'd1;
    localparam logic [1:0] FLD_RBASE = 2'd2;
    localparam logic [1:0] FLD_EN    = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RDWAIT = 2'd1,
        ST_ACK    = 2'd2
    } req_st_e;
endpackage

// File: rtl/wlr_win_map.sv
module wlr_win_map
    import wlr_pkg::*;
#(
    parameter int              NUM_WIN = 4,
    parameter int              TOW     = 16,
    parameter logic [TOW-1:0]  TO_DEF  = 16'd200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [WORD_W-1:0] lk_addr,
    output logic              hit,
    output logic [WORD_W-1:0] rmt_addr,
    output logic [TOW-1:0]    to_lim
);
    typedef struct packed {
        logic [WORD_W-1:0] lb;
        logic [WORD_W-1:0] mk;
        logic [WORD_W-1:0] rb;
        logic              en;
    } win_t;

    typedef struct packed {
        win_t [NUM_WIN-1:0] w;
        logic [TOW-1:0]     to;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (cfg_we) begin
            if (cfg_addr[4]) begin
                c_d.to = cfg_wdata[TOW-1:0];
            end else begin
                for (int i = 0; i < NUM_WIN; i++) begin
                    if (cfg_addr[3:2] == 2'(i)) begin
                        case (cfg_addr[1:0])
                            FLD_LBASE: c_d.w[i].lb = cfg_wdata;
                            FLD_MASK:  c_d.w[i].mk = cfg_wdata;
                            FLD_RBASE: c_d.w[i].rb = cfg_wdata;
                            default:   c_d.w[i].en = cfg_wdata[0];
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.to <= TO_DEF;
        end else begin
            c_q <= c_d;
        end
    end

    logic [NUM_WIN-1:0]             hv;
    logic [NUM_WIN-1:0][WORD_W-1:0] rv;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign hv[g] = c_q.w[g].en &&
                       (((lk_addr ^ c_q.w[g].lb) & c_q.w[g].mk) == '0);
        assign rv[g] = lk_addr - c_q.w[g].lb + c_q.w[g].rb;
    end

    // lowest index wins: scan downward so it overwrites last
    always_comb begin
        hit      = 1'b0;
        rmt_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit      = 1'b1;
                rmt_addr = rv[i];
            end
        end
    end

    assign to_lim = c_q.to;
endmodule

// File: rtl/wlr_tx_ser.sv
module wlr_tx_ser
    import wlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              is_wr,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output logic              busy,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    localparam int NB  = 1 + 2 * WORD_BY;
    localparam int SHW = NB * BYTE_W;
    localparam int CW  = $clog2(NB + 1);

    typedef struct packed {
        logic [SHW-1:0] sh;
        logic [CW-1:0]  left;
    } tx_t;

    tx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.left != '0 && tx_ready) begin
            s_d.sh   = {s_q.sh[SHW-BYTE_W-1:0], {BYTE_W{1'b0}}};
            s_d.left = s_q.left - 1'b1;
        end
        if (load && s_q.left == '0) begin
            s_d.sh   = {(is_wr ? TYPE_WR : TYPE_RD), addr, data};
            s_d.left = is_wr ? CW'(NB) : CW'(1 + WORD_BY);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = (s_q.left != '0);
    assign tx_valid = busy;
    assign tx_data  = s_q.sh[SHW-1 -: BYTE_W];
endmodule

// File: rtl/wlr_rx_parse.sv
module wlr_rx_parse
    import wlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_data
);
    localparam int CW = $clog2(WORD_BY + 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] dat;
        logic              done;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (rx_valid) begin
            if (r_q.cnt == '0) begin
                if (rx_data == TYPE_RSP) r_d.cnt = CW'(1);
            end else begin
                r_d.dat = {r_q.dat[WORD_W-BYTE_W-1:0], rx_data};
                if (r_q.cnt == CW'(WORD_BY)) begin
                    r_d.cnt  = '0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_done = r_q.done;
    assign rsp_data = r_q.dat;
endmodule

// File: rtl/win_link_req.sv
module win_link_req
    import wlr_pkg::*;
#(
    parameter int             NUM_WIN = 4,
    parameter int             TOW     = 16,
    parameter logic [TOW-1:0] TO_DEF  = 16'd200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic        bus_err,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data
);
    logic              hit;
    logic [WORD_W-1:0] rmt_addr;
    logic [TOW-1:0]    to_lim;
    logic              tx_busy;
    logic              load;
    logic              rsp_done;
    logic [WORD_W-1:0] rsp_data;

    wlr_win_map #(.NUM_WIN(NUM_WIN), .TOW(TOW), .TO_DEF(TO_DEF)) u_map (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .lk_addr(bus_addr), .hit(hit), .rmt_addr(rmt_addr), .to_lim(to_lim)
    );

    wlr_tx_ser u_tx (
        .clk(clk), .rst_n(rst_n),
        .load(load), .is_wr(bus_we), .addr(rmt_addr), .data(bus_wdata),
        .busy(tx_busy), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    wlr_rx_parse u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rsp_done(rsp_done), .rsp_data(rsp_data)
    );

    typedef struct packed {
        req_st_e           st;
        logic              ready;
        logic              err;
        logic [WORD_W-1:0] rdata;
        logic [TOW-1:0]    tmr;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.ready = 1'b0;
        load      = 1'b0;
        case (f_q.st)
            ST_IDLE: begin
                if (bus_req) begin
                    if (!hit) begin
                        f_d.ready = 1'b1;
                        f_d.err   = 1'b1;
                        f_d.rdata = '0;
                        f_d.st    = ST_ACK;
                    end else if (!tx_busy) begin
                        load = 1'b1;
                        if (bus_we) begin
                            f_d.ready = 1'b1;
                            f_d.err   = 1'b0;
                            f_d.rdata = '0;
                            f_d.st    = ST_ACK;
                        end else begin
                            f_d.tmr = '0;
                            f_d.st  = ST_RDWAIT;
                        end
                    end
                end
            end
            ST_RDWAIT: begin
                if (rsp_done) begin
                    f_d.ready = 1'b1;
                    f_d.err   = 1'b0;
                    f_d.rdata = rsp_data;
                    f_d.st    = ST_ACK;
                end else if (f_q.tmr == to_lim) begin
                    f_d.ready = 1'b1;
                    f_d.err   = 1'b1;
                    f_d.rdata = '1;
                    f_d.st    = ST_ACK;
                end else begin
                    f_d.tmr = f_q.tmr + 1'b1;
                end
            end
            default: begin
                f_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign bus_ready = f_q.ready;
    assign bus_err   = f_q.err;
    assign bus_rdata = f_q.rdata;
endmodule

// File: rtl/wlr_checker.sv
module wlr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_ready,
    input logic        bus_err,
    input logic [31:0] bus_rdata,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        rsp_done
);
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_ack_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> $past(bus_req));

    p_err_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_err) |-> (bus_rdata == 32'h0 || bus_rdata == 32'hFFFF_FFFF));

    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind win_link_req wlr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rsp_done(rsp_done)
);

// File: tb/sim_win_link_req.sv
module sim_win_link_req;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_err;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;

    always #5 clk = ~clk;

    win_link_req u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] txq [256];
    int tx_cnt = 0;

    always @(negedge clk) begin
        if (tx_valid && tx_ready && tx_cnt < 256) begin
            txq[tx_cnt] = tx_data;
            tx_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_rsp(input logic [31:0] d, input bit junk);
        if (junk) begin
            rx_valid = 1'b1; rx_data = 8'h55;
            @(negedge clk);
        end
        rx_valid = 1'b1; rx_data = 8'h82;
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk);
            rx_data = d[i*8 +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic bus_acc(input bit we, input logic [31:0] a, input logic [31:0] wd,
                           output logic [31:0] rd, output logic er, output int cyc);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        cyc = 0;
        rd = '0; er = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            cyc++;
            if (bus_ready) begin
                rd = bus_rdata; er = bus_err;
                break;
            end
        end
        bus_req = 1'b0;
    endtask

    task automatic run(input bit we, input logic [31:0] a, input logic [31:0] wd,
                       input bit rsp_en, input int dly, input bit junk,
                       output logic [31:0] rd, output logic er, output int cyc);
        int base;
        base = tx_cnt;
        fork
            bus_acc(we, a, wd, rd, er, cyc);
            begin
                if (rsp_en) begin
                    wait (tx_cnt >= base + 5);
                    repeat (dly) @(negedge clk);
                    send_rsp(wd, junk);
                end
            end
        join
    endtask

    // {we, addr, data/response, expect_err, expect_remote}
    localparam logic [97:0] VEC [6] = '{
        {1'b1, 32'h1000_0010, 32'hDEAD_BEEF, 1'b0, 32'h8000_0010},
        {1'b1, 32'h1001_0004, 32'hA5A5_0F0F, 1'b0, 32'h4001_0004},
        {1'b0, 32'h2000_0100, 32'h1234_5678, 1'b0, 32'h0000_1100},
        {1'b1, 32'h3000_0000, 32'h0000_0001, 1'b1, 32'h0},
        {1'b0, 32'h1000_0020, 32'hCAFE_F00D, 1'b0, 32'h8000_0020},
        {1'b0, 32'h5000_0000, 32'h0BAD_0BAD, 1'b1, 32'h0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er;
        int cyc, base, nb;

        repeat (3) @(negedge clk);
        chk(bus_ready == 1'b0, "R11 ready after reset", {31'b0, bus_ready}, 32'h0);
        chk(tx_valid == 1'b0, "R11 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // windows disabled after reset
        base = tx_cnt;
        run(1'b1, 32'h1000_0010, 32'h1, 1'b0, 0, 1'b0, rd, er, cyc);
        repeat (4) @(negedge clk);
        chk(er == 1'b1, "R11 R1 no window after reset", {31'b0, er}, 32'h1);
        chk(tx_cnt == base, "R4 no bytes on miss", tx_cnt, base);

        cfg_wr(5'h00, 32'h1000_0000); cfg_wr(5'h01, 32'hFFFF_0000);
        cfg_wr(5'h02, 32'h8000_0000); cfg_wr(5'h03, 32'h1);
        cfg_wr(5'h04, 32'h1000_0000); cfg_wr(5'h05, 32'hFF00_0000);
        cfg_wr(5'h06, 32'h4000_0000); cfg_wr(5'h07, 32'h1);
        cfg_wr(5'h08, 32'h2000_0000); cfg_wr(5'h09, 32'hFFF0_0000);
        cfg_wr(5'h0A, 32'h0000_1000); cfg_wr(5'h0B, 32'h1);
        cfg_wr(5'h0C, 32'h6000_0000); cfg_wr(5'h0D, 32'hFF00_0000);
        cfg_wr(5'h0E, 32'h7000_0000); cfg_wr(5'h0F, 32'h0);

        foreach (VEC[i]) begin
            logic        v_we;
            logic [31:0] v_a, v_d, v_r;
            logic        v_e;
            {v_we, v_a, v_d, v_e, v_r} = VEC[i];
            base = tx_cnt;
            run(v_we, v_a, v_d, !v_we && !v_e, 3, 1'b0, rd, er, cyc);
            repeat (12) @(negedge clk);
            chk(er == v_e, "R1 R4 error flag", {31'b0, er}, {31'b0, v_e});
            if (v_e) begin
                chk(tx_cnt == base, "R4 miss sends nothing", tx_cnt, base);
                chk(rd == 32'h0, "R4 miss data", rd, 32'h0);
            end else begin
                nb = v_we ? 9 : 5;
                chk(tx_cnt - base == nb, "R5 R6 packet length", tx_cnt - base, nb);
                chk(txq[base] == (v_we ? 8'h01 : 8'h02), "R5 R6 type byte",
                    {24'b0, txq[base]}, v_we ? 32'h1 : 32'h2);
                chk({txq[base+1], txq[base+2], txq[base+3], txq[base+4]} == v_r,
                    "R2 R3 remote address",
                    {txq[base+1], txq[base+2], txq[base+3], txq[base+4]}, v_r);
                if (v_we) begin
                    chk({txq[base+5], txq[base+6], txq[base+7], txq[base+8]} == v_d,
                        "R5 write data bytes",
                        {txq[base+5], txq[base+6], txq[base+7], txq[base+8]}, v_d);
                    chk(cyc <= 2, "R5 posted write latency", cyc, 2);
                end else begin
                    chk(rd == v_d, "R7 read data", rd, v_d);
                    chk(cyc > 8, "R6 read held until response", cyc, 9);
                end
            end
        end

        // disabled window must not match
        base = tx_cnt;
        run(1'b1, 32'h6000_0004, 32'h5, 1'b0, 0, 1'b0, rd, er, cyc);
        repeat (4) @(negedge clk);
        chk(er == 1'b1, "R1 disabled window", {31'b0, er}, 32'h1);
        chk(tx_cnt == base, "R1 disabled window no bytes", tx_cnt, base);

        // stray response, then a real read preceded by a junk byte
        send_rsp(32'hFEED_0001, 1'b0);
        repeat (3) @(negedge clk);
        run(1'b0, 32'h1000_0040, 32'h1122_3344, 1'b1, 2, 1'b1, rd, er, cyc);
        chk(rd == 32'h1122_3344 && er == 1'b0, "R8 R7 stray response discarded", rd, 32'h1122_3344);

        // timeout
        cfg_wr(5'h10, 32'd20);
        base = tx_cnt;
        run(1'b0, 32'h1000_0050, 32'h0, 1'b0, 0, 1'b0, rd, er, cyc);
        chk(er == 1'b1, "R9 timeout error", {31'b0, er}, 32'h1);
        chk(rd == 32'hFFFF_FFFF, "R9 timeout data", rd, 32'hFFFF_FFFF);
        chk(cyc >= 20 && cyc <= 24, "R9 timeout latency", cyc, 22);
        chk(tx_cnt - base == 5, "R6 read packet sent before timeout", tx_cnt - base, 5);

        // backpressure: posted write, held byte, second write waits
        @(negedge clk);
        tx_ready = 1'b0;
        base = tx_cnt;
        run(1'b1, 32'h1000_0060, 32'h0102_0304, 1'b0, 0, 1'b0, rd, er, cyc);
        chk(cyc <= 2 && er == 1'b0, "R5 posted under backpressure", cyc, 2);
        repeat (5) @(negedge clk);
        chk(tx_valid && tx_data == 8'h01, "R10 byte held while stalled", {24'b0, tx_data}, 32'h1);
        fork
            run(1'b1, 32'h1000_0070, 32'h0506_0708, 1'b0, 0, 1'b0, rd, er, cyc);
            begin
                repeat (10) @(negedge clk);
                tx_ready = 1'b1;
            end
        join
        chk(cyc > 10, "R12 second write held not-ready", cyc, 11);
        repeat (14) @(negedge clk);
        chk(tx_cnt - base == 18, "R12 both packets sent", tx_cnt - base, 18);
        chk(txq[base+9] == 8'h01 && txq[base+17] == 8'h08, "R5 second packet order",
            {24'b0, txq[base+17]}, 32'h8);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule